// File: doc/BRIEF.md
# Strided Vector Load Engine over Interleaved Banks

This block fetches a vector of elements from a word memory that is spread across eight banks. The low address bits pick the bank. A command gives a base address, a stride and an element count. The engine walks the addresses base, base+stride, base+2·stride and so on, modulo the address space. It starts at most one bank access per clock.

A bank that has just been accessed needs time to recover. While it recovers, the engine stalls rather than issue to it. How often it stalls therefore depends on how many distinct banks the stride visits, which is 8/gcd(8, stride). Each access returns its word a fixed latency later. The words come out in issue order on a valid/data/index stream, and a done pulse marks the last one.

A cycle counter measures the run from command acceptance to done, so stall behaviour can be measured directly. While the engine is idle, a write port fills the banks before a command is given.

Top module: `strided_bank_loader`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low and `cycle_count` is zero.
- R2: Element i is read from word address (base + i·stride) mod 1024. That word lives in bank address[2:0] at row address[9:3]. Elements are returned in ascending order of i, and `out_index` equals i.
- R3: At most one access is issued per cycle. A bank accessed in cycle t accepts its next access no earlier than cycle t+6.
- R4: A word appears on `out_valid`/`out_data` exactly 12 cycles after its access is issued. The first access of a command is issued on the cycle after acceptance, so the first element appears 13 cycles after the accepting edge.
- R5: At `done`, `cycle_count` equals the cycle in which the last access was issued plus 12. Cycles are counted from the accepting edge, and a stride-1, 64-element load gives 76. `cycle_count` holds its value while idle.
- R6: An odd stride never stalls: `cycle_count` at done equals count + 12.
- R7: Strides that touch fewer than 6 banks stall. Stride 8, which maps every access to one bank, gives 6·(count−1) + 13 at done.
- R8: `done` pulses for one cycle together with the last element. `busy` is low in the following cycle.
- R9: A preload write presented while `busy` is high is ignored and does not change memory contents.
- R10: `cmd_start` is ignored while `busy` is high, and it is also ignored when `cmd_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Preload write strobe (honoured only while idle) |
| wr_addr | input | 10 | Preload word address |
| wr_data | input | 16 | Preload word |
| cmd_start | input | 1 | Command strobe |
| cmd_base | input | 10 | Base word address |
| cmd_stride | input | 10 | Address stride (wraps modulo 1024) |
| cmd_count | input | 8 | Number of elements, 1 to 255 |
| busy | output | 1 | A command is in progress |
| out_valid | output | 1 | Returned element valid |
| out_data | output | 16 | Returned element |
| out_index | output | 8 | Element index of `out_data` |
| done | output | 1 | Last element of the command is on the output |
| cycle_count | output | 32 | Cycles from command acceptance to done |

## Verification
The assertions assume that reset is applied before the first command. They also assume that a pipeline entry exists only for a command that is running; this holds because a new command can only be accepted once the previous one has drained. The bank-spacing and ordering checks further assume that the busy time is at least two cycles, which holds at the default parameters. The stimulus drives commands only from the idle state, with counts of at least one, except in the directed cases that probe R9 and R10. Random bases and strides stay within the 10-bit address field, and the engine wraps them, so every stimulus is a legal address sequence.

// File: rtl/strided_bank_loader.sv
module strided_bank_loader #(
  parameter int NBANK = 8,
  parameter int BUSY  = 6,
  parameter int LAT   = 12,
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int TW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cmd_start,
  input  logic [AW-1:0] cmd_base,
  input  logic [AW-1:0] cmd_stride,
  input  logic [CW-1:0] cmd_count,
  output logic          busy,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_index,
  output logic          done,
  output logic [TW-1:0] cycle_count
);
  localparam int LB    = $clog2(NBANK);
  localparam int RW    = AW - LB;
  localparam int DEPTH = 1 << RW;
  localparam int BCW   = $clog2(BUSY + 1);

  logic          running;
  logic [AW-1:0] addr_q, stride_q;
  logic [CW-1:0] count_q, issued;
  logic [DW-1:0] mem [NBANK][DEPTH];
  logic [BCW-1:0] bcnt [NBANK];
  logic [LAT:0]  pv;
  logic [DW-1:0] pd [LAT+1];
  logic [CW-1:0] pi [LAT+1];

  wire [LB-1:0] cur_bank = addr_q[LB-1:0];
  wire [RW-1:0] cur_row  = addr_q[AW-1:LB];
  wire          issue    = running && (issued != count_q) && (bcnt[cur_bank] == '0);

  assign busy        = running;
  assign out_valid   = pv[LAT];
  assign out_data    = pd[LAT];
  assign out_index   = pi[LAT];
  assign done        = out_valid && (out_index == CW'(count_q - 1'b1));

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                                 bcnt[g] <= '0;
      else if (issue && cur_bank == LB'(g))       bcnt[g] <= BCW'(BUSY - 1);
      else if (bcnt[g] != '0)                     bcnt[g] <= bcnt[g] - 1'b1;
    end
    always_ff @(posedge clk)
      if (wr_en && !running && wr_addr[LB-1:0] == LB'(g))
        mem[g][wr_addr[AW-1:LB]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[LAT-1:0], issue};
  end

  always_ff @(posedge clk) begin
    pd[0] <= mem[cur_bank][cur_row];
    pi[0] <= issued;
    for (int k = 1; k <= LAT; k++) begin
      pd[k] <= pd[k-1];
      pi[k] <= pi[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running     <= 1'b0;
      addr_q      <= '0;
      stride_q    <= '0;
      count_q     <= '0;
      issued      <= '0;
      cycle_count <= '0;
    end else if (!running) begin
      if (cmd_start && cmd_count != '0) begin
        running     <= 1'b1;
        addr_q      <= cmd_base;
        stride_q    <= cmd_stride;
        count_q     <= cmd_count;
        issued      <= '0;
        cycle_count <= '0;
      end
    end else begin
      if (done) running <= 1'b0;
      else      cycle_count <= cycle_count + 1'b1;
      if (issue) begin
        addr_q <= addr_q + stride_q;
        issued <= issued + 1'b1;
      end
    end
  end

  assert_bank_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue && $past(issue) |-> cur_bank != $past(cur_bank));
  assert_index_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !done |=> !out_valid || out_index == CW'($past(out_index) + 1'b1));
  assert_done_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && busy);
  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !out_valid);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    running && cmd_start |=> $stable(stride_q) && $stable(count_q));
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !cmd_start |=> $stable(cycle_count));
endmodule

// File: tb/strided_bank_loader_bench.sv
module strided_bank_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        cmd_start = 1'b0;
  logic [9:0]  cmd_base = '0, cmd_stride = '0;
  logic [7:0]  cmd_count = '0;
  logic        busy, out_valid, done;
  logic [15:0] out_data;
  logic [7:0]  out_index;
  logic [31:0] cycle_count;

  int checks = 0, fails = 0;
  logic [15:0] shadow [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  strided_bank_loader u_strided_bank_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_start(cmd_start), .cmd_base(cmd_base), .cmd_stride(cmd_stride), .cmd_count(cmd_count),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_index(out_index),
    .done(done), .cycle_count(cycle_count));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input int base, input int stride, input int n);
    int freet[8];
    int t = 0;
    int a = base;
    for (int b = 0; b < 8; b++) freet[b] = 0;
    for (int i = 0; i < n; i++) begin
      t = (t + 1 > freet[a & 7]) ? t + 1 : freet[a & 7];
      freet[a & 7] = t + 6;
      a = (a + stride) & 1023;
    end
    return t + 12;
  endfunction

  task automatic run_cmd(input int base, input int stride, input int n,
                         input bit poke, input bit restart, output int cyc);
    int k = 0, got = 0;
    int ec = exp_cycles(base, stride, n);
    bit fin = 0;
    @(negedge clk);
    cmd_base = 10'(base); cmd_stride = 10'(stride); cmd_count = 8'(n); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (poke) begin
      wr_en = 1'b1; wr_addr = 10'((base + stride) & 1023);
      wr_data = ~shadow[(base + stride) & 1023];
    end
    if (restart) begin
      cmd_start = 1'b1; cmd_base = 10'((base + 5) & 1023); cmd_stride = 10'(stride + 1); cmd_count = 8'd3;
    end
    cyc = -1;
    while (!fin) begin
      @(negedge clk);
      wr_en = 1'b0; cmd_start = 1'b0;
      k++;
      if (out_valid) begin
        chk(out_index == 8'(got), "R2 index", out_index, got);
        chk(out_data == shadow[(base + got * stride) & 1023], "R2/R9 data", out_data,
            shadow[(base + got * stride) & 1023]);
        if (got == 0) chk(k == 13, "R4 first latency", k, 13);
        got++;
      end
      if (done) begin
        chk(cycle_count == 32'(ec), "R3/R5 cycle_count", cycle_count, ec);
        chk(got == n, "R8 element count at done", got, n);
        cyc = int'(cycle_count);
        fin = 1;
      end
      if (k > 3000) begin
        chk(0, "R8 command timeout", k, ec);
        fin = 1;
      end
    end
    @(negedge clk);
    chk(!busy && !out_valid, "R8 idle after done", {busy, out_valid}, 0);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    chk(0, "watchdog", c_dummy(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
  function automatic int c_dummy(); return 190000; endfunction

  initial begin
    int cyc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 reset outputs", {busy, out_valid, done}, 0);
    chk(cycle_count == 0, "R1 reset count", cycle_count, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 10'(a); wr_data = 16'($urandom);
      shadow[a] = wr_data;
    end
    @(negedge clk); wr_en = 1'b0;

    run_cmd(0, 1, 64, 0, 0, cyc);
    chk(cyc == 76, "R5 stride1 x64", cyc, 76);
    run_cmd(3, 8, 64, 0, 0, cyc);
    chk(cyc == 6 * 63 + 13, "R7 stride8 x64", cyc, 6 * 63 + 13);
    run_cmd(5, 3, 40, 0, 0, cyc);
    chk(cyc == 52, "R6 stride3 no stall", cyc, 52);
    run_cmd(9, 7, 30, 0, 0, cyc);
    chk(cyc == 42, "R6 stride7 no stall", cyc, 42);
    run_cmd(0, 2, 32, 0, 0, cyc);
    chk(cyc > 44, "R7 stride2 stalls", cyc, 45);
    run_cmd(1, 4, 20, 0, 0, cyc);
    chk(cyc > 32, "R7 stride4 stalls", cyc, 33);
    run_cmd(1020, 1, 8, 0, 0, cyc);
    run_cmd(16, 8, 10, 1, 0, cyc);
    run_cmd(7, 5, 10, 0, 1, cyc);

    @(negedge clk);
    cmd_count = 8'd0; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, "R10 zero count ignored", {busy, out_valid}, 0);
    chk(cycle_count == 32'(cyc), "R5 count holds idle", cycle_count, cyc);

    for (int r = 0; r < 14; r++) begin
      int s = int'($urandom % 20);
      run_cmd(int'($urandom % 1024), s, 1 + int'($urandom % 48), 0, 0, cyc);
      if (s % 2 == 1) chk(cyc > 0, "R6 random odd stride", cyc, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule